// File: doc/BRIEF.md
# Game Card ROM Block-Read Controller

This controller takes an eight-byte card command and a few control settings, runs the command, and returns the resulting data to a host as 32-bit words. Command 0xB7 is a block read. It streams a decoded number of bytes from a card ROM, one word at a time. The word timing is counted in byte-times, and the block sends a DMA request and an end-of-block interrupt when they are enabled. Command 0xB8 returns a fixed chip identifier straight away. Any other command completes at once and returns all ones.

The host writes the command bytes and the settings, then pulses `start_i`. It waits for `word_ready_o` and reads the word by pulsing `rd_i`. Each read lets the controller fetch the next word. When the last word has been read, `busy_o` drops. ROM words come from a synchronous memory port: the memory captures the address in the cycle `rom_req_o` is high and presents the data on the following cycle. A block read below the protected area is redirected into a 512-byte window, and the controller flags the access.

Top module: `cardrd_ctrl`

## Requirements
- R1: After reset, `busy_o`, `word_ready_o`, `dma_req_o`, `irq_o` and `secure_err_o` are all low.
- R2: The size field gives the block length in bytes. Code 0 means no bytes, codes 1 to 6 mean 256 shifted left by the code, and code 7 means one 4-byte word. A block read delivers exactly bytes/4 words.
- R3: For opcode 0xB7 in command byte 0, the start address is {byte1, byte2, byte3, byte4}, with byte 1 most significant. Command byte i sits at `cmd_i[8*i+7:8*i]`. The first word returned is the ROM word at that address.
- R4: A block-read start address below 0x8000 is replaced by 0x8000 + (address & 0x1FF), and `secure_err_o` goes high. An address at or above 0x8000 is used unchanged and leaves `secure_err_o` low. The flag is updated at each accepted start.
- R5: The first word of a block read sets `word_ready_o` exactly (latency + 12) × byte-time clocks after the clock edge that accepted the start.
- R6: A byte-time is 5 clocks when `rate_sel_i` is 0 and 8 clocks when it is 1. It is doubled when `slow_acc_i` is 1. These inputs are sampled at start.
- R7: Each later word sets `word_ready_o` exactly 4 × byte-time clocks after the edge of the read that consumed the previous word. Its ROM address is the previous address + 4.
- R8: A read while `word_ready_o` is high clears `word_ready_o`. If no bytes remain, the same read also clears `busy_o`; otherwise `busy_o` stays high. `word_ready_o` is never high without `busy_o`.
- R9: `dma_req_o` pulses for one cycle with each block-read word completion when `dma_arm_i` is high, and stays low when it is low.
- R10: `irq_o` pulses for one cycle on completion of the last word of a block read when `irq_en_i` is high.
- R11: Opcode 0xB8 sets `word_ready_o` on the cycle after start, with data 0xC2FF01C0 and no bytes remaining. Any other opcode except 0xB7 does the same with data 0xFFFFFFFF. Neither case reads the ROM or raises `irq_o`.
- R12: A start pulse while `busy_o` is high is ignored.
- R13: A block read with size code 0 starts nothing: `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 64 | Eight command bytes, byte i at bits 8i+7:8i |
| blk_size_i | input | 3 | Block size code |
| latency_i | input | LAT_W | Initial latency in byte-times (12 are added) |
| rate_sel_i | input | 1 | 1 selects 8-clock byte-time, 0 selects 5 |
| slow_acc_i | input | 1 | Doubles the byte-time |
| start_i | input | 1 | Start pulse |
| irq_en_i | input | 1 | Enables the end-of-block interrupt |
| dma_arm_i | input | 1 | Enables the per-word DMA request |
| rd_i | input | 1 | Data port read strobe |
| rd_data_o | output | 32 | Current data word |
| word_ready_o | output | 1 | Data word available |
| busy_o | output | 1 | Command in progress |
| dma_req_o | output | 1 | One-cycle DMA request per word |
| irq_o | output | 1 | One-cycle end-of-block interrupt |
| secure_err_o | output | 1 | Last block read hit the protected area |
| rom_req_o | output | 1 | ROM fetch request |
| rom_addr_o | output | 32 | ROM fetch address |
| rom_data_i | input | 32 | ROM data, valid the cycle after the request |

## Verification
The assertions watch the handshake on every cycle. Word-ready never appears without busy. A read always clears word-ready. DMA requests and interrupts are single-cycle, and DMA requests only come with a new word. ROM fetches happen only while a word is pending, and only at addresses at or above the protected boundary. Only the bench scenarios can show the exact cycle counts for first and later words under each byte-time setting, the big-endian address assembly and remap arithmetic, the word count for each size code, and that starts during a transfer change nothing.

// File: rtl/cardrd_pkg.sv
// Package: shared types and constants for the card block-read controller.
// Assumes byte-time values stay below 32 clocks.
package cardrd_pkg;
    localparam logic [7:0] OP_BLOCK_READ = 8'hB7;
    localparam logic [7:0] OP_CHIP_ID    = 8'hB8;
    localparam int         REM_W         = 15;
    localparam int         BT_W          = 5;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_ID    = 2'd1,
        KIND_OTHER = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/cardrd_decode.sv
// Module: command decode.
// Classifies the opcode, builds the big-endian start address, applies the
// protected-area remap and turns the size code into a byte count.
// Purely combinational; bytes 5 to 7 of the command carry no meaning here.
module cardrd_decode
    import cardrd_pkg::*;
#(
    parameter logic [31:0] SEC_BASE = 32'h0000_8000,
    parameter int          WIN_BITS = 9
) (
    input  logic [63:0]      cmd_i,
    input  logic [2:0]       size_i,
    output op_kind_e         kind_o,
    output logic [31:0]      addr_o,
    output logic             secure_o,
    output logic [REM_W-1:0] bytes_o
);
    logic [31:0] raw_addr;
    logic        unused_tail_bytes;

    assign unused_tail_bytes = ^cmd_i[63:40];

    // Address: command byte 1 is the most significant.
    assign raw_addr = {cmd_i[15:8], cmd_i[23:16], cmd_i[31:24], cmd_i[39:32]};

    // Opcode classification.
    always_comb begin
        if (cmd_i[7:0] == OP_BLOCK_READ)   kind_o = KIND_READ;
        else if (cmd_i[7:0] == OP_CHIP_ID) kind_o = KIND_ID;
        else                               kind_o = KIND_OTHER;
    end

    // Redirect reads below the protected boundary into a small window.
    always_comb begin
        secure_o = (raw_addr < SEC_BASE);
        if (secure_o)
            addr_o = SEC_BASE + {{(32-WIN_BITS){1'b0}}, raw_addr[WIN_BITS-1:0]};
        else
            addr_o = raw_addr;
    end

    // Size code to byte count.
    always_comb begin
        case (size_i)
            3'd0:    bytes_o = '0;
            3'd7:    bytes_o = REM_W'(4);
            default: bytes_o = REM_W'(256) << size_i;
        endcase
    end
endmodule

// File: rtl/cardrd_bytetime.sv
// Module: byte-time selector.
// Gives the number of clocks per card byte from the rate select and the
// slow-access input. Assumes SLOW_CLKS*2 fits in BT_W bits.
module cardrd_bytetime
    import cardrd_pkg::*;
#(
    parameter int FAST_CLKS = 5,
    parameter int SLOW_CLKS = 8
) (
    input  logic            rate_sel_i,
    input  logic            slow_acc_i,
    output logic [BT_W-1:0] bt_o
);
    logic [BT_W-1:0] base;

    // Base byte-time from the rate select.
    assign base = rate_sel_i ? BT_W'(SLOW_CLKS) : BT_W'(FAST_CLKS);

    // Doubling for slow access.
    assign bt_o = slow_acc_i ? (base << 1) : base;
endmodule

// File: rtl/cardrd_timer.sv
// Module: word-delay countdown.
// On load it counts units*bt clocks. fetch_o is high one cycle before
// done_o, so a one-cycle synchronous memory can deliver in time.
// Assumes units*bt is at least 2 and that no load arrives while running.
module cardrd_timer
    import cardrd_pkg::*;
#(
    parameter int UNIT_W = 7,
    parameter int CNT_W  = UNIT_W + BT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [UNIT_W-1:0] units_i,
    input  logic [BT_W-1:0]   bt_i,
    output logic              fetch_o,
    output logic              done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Countdown register with run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(units_i) * CNT_W'(bt_i) - CNT_W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign fetch_o = run_q && (cnt_q == CNT_W'(1));
    assign done_o  = run_q && (cnt_q == '0);
endmodule

// File: rtl/cardrd_ctrl.sv
// Module: card ROM block-read controller (top).
// Runs a command on a start pulse, fetches block-read words from a
// synchronous ROM port with byte-time accurate spacing, and hands them to
// the host through a word-ready/read handshake.
// Assumes the ROM returns data the cycle after rom_req_o.
module cardrd_ctrl
    import cardrd_pkg::*;
#(
    parameter int          LAT_W    = 6,
    parameter logic [31:0] CHIP_ID  = 32'hC2FF_01C0,
    parameter logic [31:0] SEC_BASE = 32'h0000_8000,
    parameter int          WIN_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      cmd_i,
    input  logic [2:0]       blk_size_i,
    input  logic [LAT_W-1:0] latency_i,
    input  logic             rate_sel_i,
    input  logic             slow_acc_i,
    input  logic             start_i,
    input  logic             irq_en_i,
    input  logic             dma_arm_i,
    input  logic             rd_i,
    output logic [31:0]      rd_data_o,
    output logic             word_ready_o,
    output logic             busy_o,
    output logic             dma_req_o,
    output logic             irq_o,
    output logic             secure_err_o,
    output logic             rom_req_o,
    output logic [31:0]      rom_addr_o,
    input  logic [31:0]      rom_data_i
);
    localparam int UNIT_W = LAT_W + 1;
    localparam int CNT_W  = UNIT_W + BT_W;

    ctl_state_e       state_q;
    op_kind_e         kind;
    logic [31:0]      dec_addr;
    logic             dec_secure;
    logic [REM_W-1:0] dec_bytes;
    logic [BT_W-1:0]  bt_now;
    logic [BT_W-1:0]  bt_q;
    logic [31:0]      addr_q;
    logic [REM_W-1:0] remain_q;
    logic             ready_q;
    logic             accept;
    logic             go_read;
    logic             go_next;
    logic             consume;
    logic             tmr_load;
    logic [UNIT_W-1:0] tmr_units;
    logic [BT_W-1:0]  tmr_bt;
    logic             tmr_fetch;
    logic             tmr_done;

    cardrd_decode #(.SEC_BASE(SEC_BASE), .WIN_BITS(WIN_BITS)) u_decode (
        .cmd_i    (cmd_i),
        .size_i   (blk_size_i),
        .kind_o   (kind),
        .addr_o   (dec_addr),
        .secure_o (dec_secure),
        .bytes_o  (dec_bytes)
    );

    cardrd_bytetime u_bytetime (
        .rate_sel_i (rate_sel_i),
        .slow_acc_i (slow_acc_i),
        .bt_o       (bt_now)
    );

    // Handshake qualifiers.
    assign accept  = start_i && (state_q == ST_IDLE);
    assign go_read = accept && (kind == KIND_READ) && (dec_bytes != '0);
    assign consume = rd_i && ready_q && (state_q == ST_HOLD);
    assign go_next = consume && (remain_q != '0);

    // Timer load: initial latency on start, four bytes per later word.
    assign tmr_load  = go_read || go_next;
    assign tmr_units = go_read ? (UNIT_W'(latency_i) + UNIT_W'(12)) : UNIT_W'(4);
    assign tmr_bt    = go_read ? bt_now : bt_q;

    cardrd_timer #(.UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .units_i (tmr_units),
        .bt_i    (tmr_bt),
        .fetch_o (tmr_fetch),
        .done_o  (tmr_done)
    );

    // Main control state, data word and pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ready_q      <= 1'b0;
            addr_q       <= '0;
            remain_q     <= '0;
            bt_q         <= '0;
            rd_data_o    <= '0;
            dma_req_o    <= 1'b0;
            irq_o        <= 1'b0;
            secure_err_o <= 1'b0;
        end else begin
            dma_req_o <= 1'b0;
            irq_o     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && kind == KIND_READ) begin
                        secure_err_o <= dec_secure && (dec_bytes != '0);
                        if (dec_bytes != '0) begin
                            state_q  <= ST_WAIT;
                            addr_q   <= dec_addr;
                            remain_q <= dec_bytes;
                            bt_q     <= bt_now;
                        end
                    end else if (accept) begin
                        secure_err_o <= 1'b0;
                        state_q      <= ST_HOLD;
                        ready_q      <= 1'b1;
                        remain_q     <= '0;
                        rd_data_o    <= (kind == KIND_ID) ? CHIP_ID : 32'hFFFF_FFFF;
                    end
                end
                ST_WAIT: begin
                    if (tmr_done) begin
                        state_q   <= ST_HOLD;
                        ready_q   <= 1'b1;
                        rd_data_o <= rom_data_i;
                        addr_q    <= addr_q + 32'd4;
                        remain_q  <= remain_q - REM_W'(4);
                        dma_req_o <= dma_arm_i;
                        irq_o     <= irq_en_i && (remain_q == REM_W'(4));
                    end
                end
                ST_HOLD: begin
                    if (consume) begin
                        ready_q <= 1'b0;
                        state_q <= go_next ? ST_WAIT : ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign word_ready_o = ready_q;
    assign rom_req_o    = tmr_fetch;
    assign rom_addr_o   = addr_q;
endmodule

// File: rtl/cardrd_ctrl_chk.sv
// Module: protocol checker for cardrd_ctrl, attached by bind.
// Assumes block reads never wrap the 32-bit address space.
module cardrd_ctrl_chk #(
    parameter logic [31:0] SEC_BASE = 32'h0000_8000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_i,
    input logic        word_ready_o,
    input logic        busy_o,
    input logic        dma_req_o,
    input logic        irq_o,
    input logic        rom_req_o,
    input logic [31:0] rom_addr_o
);
    assert_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> busy_o);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && word_ready_o) |=> !word_ready_o);

    assert_dma_with_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> $rose(word_ready_o));

    assert_dma_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |=> !dma_req_o);

    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_fetch_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req_o |-> (busy_o && !word_ready_o));

    assert_fetch_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req_o |-> (rom_addr_o >= SEC_BASE));
endmodule

bind cardrd_ctrl cardrd_ctrl_chk #(.SEC_BASE(SEC_BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_i         (rd_i),
    .word_ready_o (word_ready_o),
    .busy_o       (busy_o),
    .dma_req_o    (dma_req_o),
    .irq_o        (irq_o),
    .rom_req_o    (rom_req_o),
    .rom_addr_o   (rom_addr_o)
);

// File: tb/cardrd_ctrl_tb.sv
// Bench: directed corners plus seeded random block reads for cardrd_ctrl.
module cardrd_ctrl_tb;
    localparam int LAT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [63:0]      cmd_i = '0;
    logic [2:0]       blk_size_i = '0;
    logic [LAT_W-1:0] latency_i = '0;
    logic             rate_sel_i = 1'b0;
    logic             slow_acc_i = 1'b0;
    logic             start_i = 1'b0;
    logic             irq_en_i = 1'b0;
    logic             dma_arm_i = 1'b0;
    logic             rd_i = 1'b0;
    logic [31:0]      rd_data_o;
    logic             word_ready_o;
    logic             busy_o;
    logic             dma_req_o;
    logic             irq_o;
    logic             secure_err_o;
    logic             rom_req_o;
    logic [31:0]      rom_addr_o;
    logic [31:0]      rom_q = '0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    cardrd_ctrl #(.LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .blk_size_i(blk_size_i),
        .latency_i(latency_i), .rate_sel_i(rate_sel_i), .slow_acc_i(slow_acc_i),
        .start_i(start_i), .irq_en_i(irq_en_i), .dma_arm_i(dma_arm_i), .rd_i(rd_i),
        .rd_data_o(rd_data_o), .word_ready_o(word_ready_o), .busy_o(busy_o),
        .dma_req_o(dma_req_o), .irq_o(irq_o), .secure_err_o(secure_err_o),
        .rom_req_o(rom_req_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_q)
    );

    function automatic logic [31:0] romf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] remap(input logic [31:0] a);
        return (a < 32'h8000) ? (32'h8000 + (a & 32'h1FF)) : a;
    endfunction

    function automatic logic [63:0] mk_cmd(input logic [7:0] op, input logic [31:0] a);
        return {24'hA1B2C3, a[7:0], a[15:8], a[23:16], a[31:24], op};
    endfunction

    // Synchronous ROM model: one-cycle read.
    always @(posedge clk) if (rom_req_o) rom_q <= romf(rom_addr_o);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic count_ready(input int c0, output int c);
        c = c0;
        while (!word_ready_o && c < 20000) begin
            @(posedge clk); c++; @(negedge clk);
        end
    endtask

    task automatic do_read();
        rd_i = 1'b1; @(posedge clk); @(negedge clk); rd_i = 1'b0;
    endtask

    task automatic pulse_start(input logic [63:0] cmd, input logic [2:0] sz);
        cmd_i = cmd; blk_size_i = sz; start_i = 1'b1;
        @(posedge clk); @(negedge clk); start_i = 1'b0;
    endtask

    task automatic run_block(input logic [31:0] a, input logic [2:0] sz,
                             input logic [LAT_W-1:0] lat, input bit rate, input bit slow,
                             input bit ien, input bit dma);
        int bt, bytes, words, c;
        logic [31:0] ea;
        bt    = (rate ? 8 : 5) << slow;
        bytes = (sz == 3'd7) ? 4 : (256 << sz);
        words = bytes / 4;
        ea    = remap(a);
        latency_i = lat; rate_sel_i = rate; slow_acc_i = slow;
        irq_en_i = ien; dma_arm_i = dma;
        pulse_start(mk_cmd(8'hB7, a), sz);
        chk("R4 secure flag", 32'(secure_err_o), 32'(a < 32'h8000));
        for (int w = 0; w < words; w++) begin
            count_ready(0, c);
            if (w == 0) chk("R5 R6 first word delay", c, (lat + 12) * bt);
            else        chk("R7 next word delay", c, 4 * bt);
            if (w == 0) chk("R3 R4 first word data", rd_data_o, romf(ea));
            else        chk("R7 word data", rd_data_o, romf(ea + 32'(4 * w)));
            chk("R9 dma request", 32'(dma_req_o), 32'(dma));
            chk("R10 irq", 32'(irq_o), 32'(ien && (w == words - 1)));
            do_read();
            chk("R8 ready cleared", 32'(word_ready_o), 32'd0);
            chk("R2 R8 busy after read", 32'(busy_o), 32'(w != words - 1));
        end
    endtask

    initial begin
        int c;
        logic [31:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 ready", 32'(word_ready_o), 0);
        chk("R1 dma", 32'(dma_req_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 secure", 32'(secure_err_o), 0);

        // R11: chip ID.
        irq_en_i = 1'b1;
        pulse_start(mk_cmd(8'hB8, 32'h0), 3'd1);
        chk("R11 id ready", 32'(word_ready_o), 1);
        chk("R11 id data", rd_data_o, 32'hC2FF_01C0);
        chk("R11 id irq", 32'(irq_o), 0);
        do_read();
        chk("R11 id busy clears", 32'(busy_o), 0);
        // R11: unknown opcode.
        pulse_start(mk_cmd(8'h9F, 32'h12345678), 3'd1);
        chk("R11 other ready", 32'(word_ready_o), 1);
        chk("R11 other data", rd_data_o, 32'hFFFF_FFFF);
        do_read();
        chk("R11 other busy clears", 32'(busy_o), 0);

        // R13: zero-size block read.
        pulse_start(mk_cmd(8'hB7, 32'h0001_0000), 3'd0);
        chk("R13 busy", 32'(busy_o), 0);
        chk("R13 ready", 32'(word_ready_o), 0);

        // R12: start while busy is ignored.
        latency_i = '0; rate_sel_i = 0; slow_acc_i = 0; dma_arm_i = 0; irq_en_i = 1;
        pulse_start(mk_cmd(8'hB7, 32'h0002_0000), 3'd7);
        repeat (3) @(negedge clk);
        pulse_start(mk_cmd(8'hB8, 32'h0), 3'd1);
        count_ready(4, c);
        chk("R12 delay unchanged", c, 60);
        chk("R12 data unchanged", rd_data_o, romf(32'h0002_0000));
        chk("R12 irq single word", 32'(irq_o), 1);
        do_read();
        chk("R12 busy clears", 32'(busy_o), 0);

        // Directed remap and sizes.
        run_block(32'h0000_1234, 3'd7, 6'd3, 1, 1, 1, 1);
        run_block(32'h0000_7FFF, 3'd7, 6'd0, 0, 1, 0, 0);
        run_block(32'h0012_3400, 3'd2, 6'd1, 0, 0, 1, 1);
        run_block(32'h0040_0000, 3'd3, 6'd0, 0, 0, 0, 1);
        run_block(32'h0100_0000, 3'd4, 6'd2, 0, 0, 1, 0);

        // Random block reads.
        for (int i = 0; i < 8; i++) begin
            a = $urandom & 32'h0FFF_FFFF;
            if ($urandom % 3 == 0) a = $urandom % 32'h8000;
            run_block(a, ($urandom % 2) ? 3'd1 : 3'd7, LAT_W'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule